// File: doc/BRIEF.md
# Double-Buffered Byte-Lane Converter Code Register

This block is the host-facing register front end of a 16-bit parallel-load converter, reduced to its digital function. The host drives a 16-bit bus along with five asynchronous active-low controls: a write strobe, one select for each byte lane, a load strobe and a clear. It also supplies a power-on reset. The first stage is a pair of 8-bit lane registers. The second stage is a 16-bit code register. The second stage copies the first for as long as the load strobe stays low, and holds its value while load is high.

The host can write either lane alone or both lanes in one access. With a byte-wide host, the two bus halves are wired together and the host makes one access per lane. When write, both selects and load are all low together, bus data flows through both stages. A clear empties both stages at once.

The controls and the bus cross into the system clock through a two-stage synchronizer. Clear and power-on reset act on the registers asynchronously, and their release is synchronized. A one-cycle strobe marks every change of the code. A timing monitor sets a sticky flag when a low pulse on any control, or the data setup window before the end of a write, is shorter than its programmed number of cycles.

Top module: `dac_host_if`

## Requirements
- R1: After power-on reset is released, `code_o` is 0, `upd_o` is 0 and `viol_o` is 0.
- R2: A lane is written only while `wr_n_i` and that lane's select are both low. `bus_i[15:8]` goes to the high lane (select `msb_sel_n_i`) and `bus_i[7:0]` to the low lane (select `lsb_sel_n_i`). With both selects low, both lanes load in the same access.
- R3: Nothing is written to the lanes while `wr_n_i` is high, or while both selects are high.
- R4: While `ld_n_i` is low, `code_o` follows {high lane, low lane}. While `ld_n_i` is high, `code_o` holds its value.
- R5: With `wr_n_i`, both selects and `ld_n_i` all low, `code_o` follows `bus_i`.
- R6: A low `clr_n_i` zeroes `code_o` in the same cycle without waiting for a clock edge, whatever the other controls are doing. It also zeroes both lanes, so a later load yields 0.
- R7: `upd_o` is high for exactly one clock after each change of `code_o`, and this includes a change caused by clear. It stays low when a load leaves the value unchanged.
- R8: A control or bus change that settles between clock edges reaches `code_o` at the third rising edge after it settles. Before that edge the old value is kept.
- R9: A byte-wide host with `bus_i[15:8]` tied to `bus_i[7:0]` builds a full code from two writes, one per select, followed by a load.
- R10: A synchronized low pulse on any control that lasts fewer than `MIN_PULSE_CYC` clocks sets `viol_o`.
- R11: A write with a lane selected sets `viol_o` if the synchronized bus changed fewer than `MIN_SETUP_CYC` clocks before the write strobe rose.
- R12: `viol_o` stays set until power-on reset. A clear does not reset it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| bus_i | input | 16 | Host data bus |
| wr_n_i | input | 1 | Write strobe, active low |
| msb_sel_n_i | input | 1 | High lane select, active low |
| lsb_sel_n_i | input | 1 | Low lane select, active low |
| ld_n_i | input | 1 | Load strobe to code register, active low |
| clr_n_i | input | 1 | Clear of both stages, active low, asynchronous |
| code_o | output | 16 | Converter code |
| upd_o | output | 1 | One-cycle strobe on each code change |
| viol_o | output | 1 | Sticky timing violation flag |

## Verification
Synchronized inputs reach `code_o` at the third rising edge after they settle. `upd_o` follows one edge later. A clear zeroes the code at once, without waiting for an edge. The bench drives inputs one nanosecond after a falling edge. Its behavioural model takes a snapshot of the inputs at each rising edge and applies the snapshot from two edges earlier. The design's outputs are compared with the model at every falling edge. Directed checks count edges explicitly: the latency test expects the old code after two edges and the new code after three. The clear check reads the code half a nanosecond after clear falls. The violation flag is read several cycles after a pulse or setup window ends, which leaves room for the synchronizer and monitor delay.

// File: rtl/dac_if_pkg.sv
package dac_if_pkg;

    // Control channel count and positions inside ctrl_t (LSB first)
    localparam int NCH    = 5;
    localparam int CH_WR  = 0;
    localparam int CH_HI  = 1;
    localparam int CH_LO  = 2;
    localparam int CH_LD  = 3;
    localparam int CH_CLR = 4;

    // All controls are active low; the last member is bit 0
    typedef struct packed {
        logic clr_n;
        logic ld_n;
        logic lo_n;
        logic hi_n;
        logic wr_n;
    } ctrl_t;

endpackage

// File: rtl/dac_sync.sv
module dac_sync #(
    parameter int            W       = 1,
    parameter int            STAGES  = 2,
    parameter logic [W-1:0]  RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [STAGES-1:0][W-1:0] st_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= {STAGES{RST_VAL}};
        end else begin
            st_q[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                st_q[i] <= st_q[i-1];
            end
        end
    end

    assign q = st_q[STAGES-1];

endmodule

// File: rtl/dac_regs.sv
module dac_regs
    import dac_if_pkg::*;
#(
    parameter  int LANE_W = 8,
    localparam int LANES  = 2,
    localparam int DATA_W = LANE_W * LANES
) (
    input  logic              clk,
    input  logic              dp_rst_n,
    input  logic              ev_rst_n,
    input  ctrl_t             ctl,
    input  logic [DATA_W-1:0] bus,
    output logic [DATA_W-1:0] code,
    output logic              upd
);

    typedef struct packed {
        logic [LANES-1:0][LANE_W-1:0] inreg;
        logic [DATA_W-1:0]            code;
    } dp_t;

    typedef struct packed {
        logic [DATA_W-1:0] last;
        logic              upd;
    } ev_t;

    dp_t dp_d, dp_q;
    ev_t ev_d, ev_q;

    logic [LANES-1:0]             sel_n;
    logic [LANES-1:0]             lane_we;
    logic [LANES-1:0][LANE_W-1:0] lane_nx;

    // lane 1 is the high byte, lane 0 the low byte
    assign sel_n = {ctl.hi_n, ctl.lo_n};

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_we[g] = !ctl.wr_n && !sel_n[g];
        assign lane_nx[g] = lane_we[g] ? bus[g*LANE_W +: LANE_W] : dp_q.inreg[g];
    end

    always_comb begin
        dp_d       = dp_q;
        dp_d.inreg = lane_nx;
        // level-sensitive transfer; using lane_nx gives flow-through
        if (!ctl.ld_n) begin
            dp_d.code = lane_nx;
        end
        ev_d.last = dp_q.code;
        ev_d.upd  = (dp_q.code != ev_q.last);
    end

    always_ff @(posedge clk or negedge dp_rst_n) begin
        if (!dp_rst_n) dp_q <= '0;
        else           dp_q <= dp_d;
    end

    // change detector survives clear so a clear-induced change is seen
    always_ff @(posedge clk or negedge ev_rst_n) begin
        if (!ev_rst_n) ev_q <= '0;
        else           ev_q <= ev_d;
    end

    assign code = dp_q.code;
    assign upd  = ev_q.upd;

endmodule

// File: rtl/dac_timing_mon.sv
module dac_timing_mon
    import dac_if_pkg::*;
#(
    parameter  int DATA_W    = 16,
    parameter  int MIN_PULSE = 8,
    parameter  int MIN_SETUP = 8,
    localparam int LIM       = (MIN_PULSE > MIN_SETUP) ? MIN_PULSE : MIN_SETUP,
    localparam int CNT_W     = $clog2(LIM + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ctrl_t             ctl,
    input  logic [DATA_W-1:0] bus,
    output logic              viol
);

    localparam logic [CNT_W-1:0] SAT  = '1;
    localparam logic [CNT_W-1:0] MINP = CNT_W'(MIN_PULSE);
    localparam logic [CNT_W-1:0] MINS = CNT_W'(MIN_SETUP);

    typedef struct packed {
        logic [NCH-1:0][CNT_W-1:0] run;
        logic [CNT_W-1:0]          stab;
        logic [DATA_W-1:0]         bus_prev;
        logic                      viol;
    } mon_t;

    mon_t m_d, m_q;
    logic [NCH-1:0] low;

    assign low = ~ctl;

    always_comb begin
        m_d = m_q;
        for (int ch = 0; ch < NCH; ch++) begin
            if (low[ch]) begin
                m_d.run[ch] = (m_q.run[ch] == SAT) ? SAT : m_q.run[ch] + 1'b1;
            end else begin
                m_d.run[ch] = '0;
                if (m_q.run[ch] != '0 && m_q.run[ch] < MINP) begin
                    m_d.viol = 1'b1;
                end
            end
        end
        if (bus != m_q.bus_prev) m_d.stab = '0;
        else                     m_d.stab = (m_q.stab == SAT) ? SAT : m_q.stab + 1'b1;
        m_d.bus_prev = bus;
        // end of a write that had a lane selected
        if (!low[CH_WR] && m_q.run[CH_WR] != '0 &&
            (m_q.run[CH_HI] != '0 || m_q.run[CH_LO] != '0) &&
            m_q.stab < MINS) begin
            m_d.viol = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) m_q <= '0;
        else        m_q <= m_d;
    end

    assign viol = m_q.viol;

endmodule

// File: rtl/dac_host_if.sv
module dac_host_if
    import dac_if_pkg::*;
#(
    parameter  int LANE_W        = 8,
    parameter  int SYNC_STAGES   = 2,
    parameter  int MIN_PULSE_CYC = 8,
    parameter  int MIN_SETUP_CYC = 8,
    localparam int DATA_W        = 2 * LANE_W,
    localparam int SYNC_W        = NCH + DATA_W
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic [DATA_W-1:0] bus_i,
    input  logic              wr_n_i,
    input  logic              msb_sel_n_i,
    input  logic              lsb_sel_n_i,
    input  logic              ld_n_i,
    input  logic              clr_n_i,
    output logic [DATA_W-1:0] code_o,
    output logic              upd_o,
    output logic              viol_o
);

    logic              por_rst_n;
    logic              clr_arst_n;
    logic              dp_rst_n;
    ctrl_t             ctl_raw;
    ctrl_t             ctl_s;
    logic [DATA_W-1:0] bus_s;
    logic [SYNC_W-1:0] sync_in;
    logic [SYNC_W-1:0] sync_out;

    assign clr_arst_n = por_n & clr_n_i;

    // asynchronous assertion, synchronized release
    dac_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_por_sync (
        .clk   (clk),
        .rst_n (por_n),
        .d     (1'b1),
        .q     (por_rst_n)
    );

    dac_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_clr_sync (
        .clk   (clk),
        .rst_n (clr_arst_n),
        .d     (1'b1),
        .q     (dp_rst_n)
    );

    assign ctl_raw = '{clr_n: clr_n_i, ld_n: ld_n_i, lo_n: lsb_sel_n_i,
                       hi_n: msb_sel_n_i, wr_n: wr_n_i};
    assign sync_in = {ctl_raw, bus_i};

    // controls and bus share one synchronizer so they stay aligned
    dac_sync #(
        .W       (SYNC_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL ({{NCH{1'b1}}, {DATA_W{1'b0}}})
    ) u_in_sync (
        .clk   (clk),
        .rst_n (por_rst_n),
        .d     (sync_in),
        .q     (sync_out)
    );

    assign ctl_s = ctrl_t'(sync_out[SYNC_W-1:DATA_W]);
    assign bus_s = sync_out[DATA_W-1:0];

    dac_regs #(.LANE_W(LANE_W)) u_regs (
        .clk      (clk),
        .dp_rst_n (dp_rst_n),
        .ev_rst_n (por_rst_n),
        .ctl      (ctl_s),
        .bus      (bus_s),
        .code     (code_o),
        .upd      (upd_o)
    );

    dac_timing_mon #(
        .DATA_W    (DATA_W),
        .MIN_PULSE (MIN_PULSE_CYC),
        .MIN_SETUP (MIN_SETUP_CYC)
    ) u_mon (
        .clk   (clk),
        .rst_n (por_rst_n),
        .ctl   (ctl_s),
        .bus   (bus_s),
        .viol  (viol_o)
    );

endmodule

// File: rtl/dac_if_chk.sv
module dac_if_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              por_n,
    input logic              clr_n_i,
    input logic              ld_n_i,
    input logic [DATA_W-1:0] code_o,
    input logic              upd_o,
    input logic              viol_o
);

    // R6
    clear_zero_chk: assert property (@(posedge clk) disable iff (!por_n)
        !clr_n_i |-> code_o == '0);

    // R4
    load_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
        (clr_n_i && $past(clr_n_i) && $past(clr_n_i, 2) && $past(clr_n_i, 3) &&
         $past(ld_n_i, 3)) |-> $stable(code_o));

    // R7
    upd_change_chk: assert property (@(posedge clk) disable iff (!por_n)
        upd_o == ($past(code_o) != $past(code_o, 2)));

    // R12
    viol_sticky_chk: assert property (@(posedge clk) disable iff (!por_n)
        viol_o |=> viol_o);

endmodule

bind dac_host_if dac_if_chk #(.DATA_W(DATA_W)) u_chk (
    .clk     (clk),
    .por_n   (por_n),
    .clr_n_i (clr_n_i),
    .ld_n_i  (ld_n_i),
    .code_o  (code_o),
    .upd_o   (upd_o),
    .viol_o  (viol_o)
);

// File: tb/sim_dac_host_if.sv
`timescale 1ns/1ps
module sim_dac_host_if;

    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic [15:0] bus = 16'h0;
    logic        wr_n = 1'b1, msb_n = 1'b1, lsb_n = 1'b1, ld_n = 1'b1, clr_n = 1'b1;
    logic [15:0] code_o;
    logic        upd_o, viol_o;

    int    checks = 0;
    int    fails = 0;
    int    upd_cnt = 0;
    bit    cmp_en = 1'b0;
    bit    done = 1'b0;
    string req = "R1";

    always #2.5 clk = ~clk;

    dac_host_if u0 (
        .clk(clk), .por_n(por_n), .bus_i(bus), .wr_n_i(wr_n),
        .msb_sel_n_i(msb_n), .lsb_sel_n_i(lsb_n), .ld_n_i(ld_n),
        .clr_n_i(clr_n), .code_o(code_o), .upd_o(upd_o), .viol_o(viol_o)
    );

    // behavioural reference model
    logic [7:0]  m_hi = 8'h0, m_lo = 8'h0;
    logic [15:0] m_code = 16'h0, m_pre = 16'h0;
    logic        m_upd = 1'b0;
    logic [4:0]  h_ctl [3];
    logic [15:0] h_bus [3];

    initial begin
        for (int i = 0; i < 3; i++) begin
            h_ctl[i] = 5'b11111;
            h_bus[i] = 16'h0;
        end
    end

    always @(posedge clk) begin
        logic [15:0] pre;
        if (!por_n) begin
            m_hi = 8'h0; m_lo = 8'h0; m_code = 16'h0; m_pre = 16'h0; m_upd = 1'b0;
            for (int i = 0; i < 3; i++) begin
                h_ctl[i] = 5'b11111;
                h_bus[i] = 16'h0;
            end
        end else begin
            pre   = clr_n ? m_code : 16'h0;
            m_upd = (pre != m_pre);
            m_pre = pre;
            h_ctl[2] = h_ctl[1]; h_ctl[1] = h_ctl[0];
            h_ctl[0] = {clr_n, ld_n, lsb_n, msb_n, wr_n};
            h_bus[2] = h_bus[1]; h_bus[1] = h_bus[0]; h_bus[0] = bus;
            if (!h_ctl[0][4] || !h_ctl[1][4] || !h_ctl[2][4]) begin
                m_hi = 8'h0; m_lo = 8'h0; m_code = 16'h0;
            end else begin
                if (!h_ctl[2][0] && !h_ctl[2][1]) m_hi = h_bus[2][15:8];
                if (!h_ctl[2][0] && !h_ctl[2][2]) m_lo = h_bus[2][7:0];
                if (!h_ctl[2][3]) m_code = {m_hi, m_lo};
            end
        end
    end

    task automatic chk(input bit ok, input string r, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", r, what, act, exp);
        end
    endtask

    // cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (cmp_en && por_n && !done) begin
            chk(code_o === m_code, req, "code vs model", 32'(code_o), 32'(m_code));
            chk(upd_o === m_upd, req, "upd vs model", 32'(upd_o), 32'(m_upd));
            if (upd_o) upd_cnt++;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic do_write(input logic [15:0] d, input bit h, input bit l);
        bus = d; msb_n = !h; lsb_n = !l; wr_n = 1'b0;
        tick(12);
        wr_n = 1'b1;
        tick(1);
        msb_n = 1'b1; lsb_n = 1'b1;
        tick(2);
    endtask

    task automatic do_load;
        ld_n = 1'b0;
        tick(12);
        ld_n = 1'b1;
        tick(4);
    endtask

    task automatic power_cycle;
        cmp_en = 1'b0;
        por_n = 1'b0;
        tick(4);
        por_n = 1'b1;
        tick(10);
        cmp_en = 1'b1;
    endtask

    initial begin
        tick(5);
        por_n = 1'b1;
        tick(10);
        cmp_en = 1'b1;

        req = "R1";
        chk(code_o == 16'h0, "R1", "code after reset", 32'(code_o), 0);
        chk(upd_o == 1'b0, "R1", "upd after reset", 32'(upd_o), 0);
        chk(viol_o == 1'b0, "R1", "viol after reset", 32'(viol_o), 0);

        req = "R2";
        do_write(16'hA55A, 1, 1);
        do_load();
        chk(code_o == 16'hA55A, "R2", "both lanes", 32'(code_o), 32'hA55A);

        req = "R9";
        do_write(16'h1212, 1, 0);
        do_write(16'h3434, 0, 1);
        do_load();
        chk(code_o == 16'h1234, "R9", "byte-wide pair", 32'(code_o), 32'h1234);

        req = "R3";
        bus = 16'hFFFF; msb_n = 1'b0; lsb_n = 1'b0;
        tick(14);
        msb_n = 1'b1; lsb_n = 1'b1;
        tick(2);
        wr_n = 1'b0;
        tick(12);
        wr_n = 1'b1;
        tick(2);
        do_load();
        chk(code_o == 16'h1234, "R3", "inhibited writes", 32'(code_o), 32'h1234);

        req = "R4";
        do_write(16'hBEEF, 1, 1);
        tick(5);
        chk(code_o == 16'h1234, "R4", "hold while load high", 32'(code_o), 32'h1234);
        do_load();
        chk(code_o == 16'hBEEF, "R4", "transfer on load", 32'(code_o), 32'hBEEF);
        ld_n = 1'b0;
        do_write(16'h0F0F, 1, 1);
        chk(code_o == 16'h0F0F, "R4", "follow while load low", 32'(code_o), 32'h0F0F);
        do_write(16'hF0F0, 0, 1);
        chk(code_o == 16'h0FF0, "R4", "follow low lane only", 32'(code_o), 32'h0FF0);
        ld_n = 1'b1;
        tick(4);

        req = "R8";
        do_write(16'h5A5A, 1, 1);
        ld_n = 1'b0;
        @(negedge clk); @(negedge clk); #1;
        chk(code_o == 16'h0FF0, "R8", "old code after two edges", 32'(code_o), 32'h0FF0);
        @(negedge clk); #1;
        chk(code_o == 16'h5A5A, "R8", "new code after third edge", 32'(code_o), 32'h5A5A);
        tick(10);
        ld_n = 1'b1;
        tick(4);

        req = "R5";
        bus = 16'h1111; wr_n = 1'b0; msb_n = 1'b0; lsb_n = 1'b0; ld_n = 1'b0;
        @(negedge clk); @(negedge clk); @(negedge clk); #1;
        chk(code_o == 16'h1111, "R5", "flow-through first", 32'(code_o), 32'h1111);
        bus = 16'h2222;
        @(negedge clk); @(negedge clk); @(negedge clk); #1;
        chk(code_o == 16'h2222, "R5", "flow-through second", 32'(code_o), 32'h2222);
        tick(12);
        wr_n = 1'b1; ld_n = 1'b1;
        tick(1);
        msb_n = 1'b1; lsb_n = 1'b1;
        tick(4);

        req = "R7";
        upd_cnt = 0;
        do_load();
        tick(2);
        chk(upd_cnt == 0, "R7", "no strobe on same value", 32'(upd_cnt), 0);
        do_write(16'h3333, 1, 1);
        upd_cnt = 0;
        do_load();
        tick(2);
        chk(upd_cnt == 1, "R7", "one strobe per change", 32'(upd_cnt), 1);

        req = "R6";
        upd_cnt = 0;
        bus = 16'hFFFF; wr_n = 1'b0; msb_n = 1'b0; lsb_n = 1'b0; ld_n = 1'b0;
        clr_n = 1'b0;
        #0.5;
        chk(code_o == 16'h0, "R6", "immediate clear", 32'(code_o), 0);
        tick(12);
        chk(code_o == 16'h0, "R6", "clear dominates", 32'(code_o), 0);
        wr_n = 1'b1; ld_n = 1'b1; msb_n = 1'b1; lsb_n = 1'b1;
        tick(4);
        clr_n = 1'b1;
        tick(6);
        chk(upd_cnt == 1, "R7", "strobe on clear", 32'(upd_cnt), 1);
        do_load();
        chk(code_o == 16'h0, "R6", "lanes cleared", 32'(code_o), 0);
        chk(viol_o == 1'b0, "R11", "no violation on legal traffic", 32'(viol_o), 0);

        req = "R11";
        msb_n = 1'b0; bus = 16'h4444; wr_n = 1'b0;
        tick(10);
        bus = 16'h5555;
        tick(2);
        wr_n = 1'b1;
        tick(1);
        msb_n = 1'b1;
        tick(6);
        chk(viol_o == 1'b1, "R11", "short setup flagged", 32'(viol_o), 1);

        req = "R12";
        clr_n = 1'b0;
        tick(12);
        clr_n = 1'b1;
        tick(6);
        chk(viol_o == 1'b1, "R12", "clear keeps flag", 32'(viol_o), 1);
        power_cycle();
        chk(viol_o == 1'b0, "R12", "power-on clears flag", 32'(viol_o), 0);
        chk(code_o == 16'h0, "R1", "code after second reset", 32'(code_o), 0);

        req = "R10";
        wr_n = 1'b0;
        tick(2);
        wr_n = 1'b1;
        tick(8);
        chk(viol_o == 1'b1, "R10", "short write pulse", 32'(viol_o), 1);
        power_cycle();
        ld_n = 1'b0;
        tick(2);
        ld_n = 1'b1;
        tick(8);
        chk(viol_o == 1'b1, "R10", "short load pulse", 32'(viol_o), 1);
        power_cycle();
        chk(viol_o == 1'b0, "R10", "flag clear after reset", 32'(viol_o), 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule